// File: doc/BRIEF.md
# Integer overflow flag unit

This block sits beside the integer datapath of a 32-bit fixed-point execution unit. It looks at the operation that just executed: an operation code, both source operands and the result. From these it works out whether the operation overflowed. Each operation class has its own overflow rule. The block returns that decision at once on a combinational output.

The block also holds the fixed-point flag register. This register has four fields: a sticky summary-overflow bit, an overflow bit, a carry bit and an 8-bit byte count. When the overflow-enable strobe is high, the overflow bit takes the new decision and the summary bit collects it. Software moves the whole register as one packed word: every field can be loaded with a write and is always visible on the read port.

The carry field and the byte count change only through a register write. Computing results and generating carry belong to the surrounding datapath.

Top module: `ovf_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears all four fields, so the packed word reads 0x00000000 after reset.
- R2: For op codes 0 (add) and 1 (add-extended), the overflow output is 1 exactly when the two operands have equal sign bits and the sign bit of the result differs from the sign bit of the first operand.
- R3: For op codes 6, 7 and 8 (subtract-from, subtract-from-carrying, subtract-from-extended), the rule of R2 applies with the bitwise inverse of the first operand used in place of the first operand.
- R4: For op code 2 (signed divide), the overflow output is 1 when the second operand (divisor) is zero, or when the first operand is 0x80000000 and the second operand is 0xFFFFFFFF.
- R5: For op code 3 (unsigned divide), the overflow output is 1 only when the divisor is zero.
- R6: For op code 4 (multiply-low), the overflow output is 1 when the upper 32 bits of the signed 64-bit product of the operands differ from the sign extension of its lower 32 bits.
- R7: For op code 5 (negate), the overflow output is 1 only when the first operand equals 0x80000000.
- R8: On a clock edge where the overflow-enable strobe is high and no write takes place, the overflow field takes the new overflow value, and the summary field becomes its old value OR that value. The carry and byte-count fields stay unchanged.
- R9: When the overflow-enable strobe is low and no write takes place, all four fields hold their values, whatever the operation inputs are.
- R10: In the packed word, summary overflow is bit 31, overflow is bit 30, carry is bit 29 and the byte count is bits 7:0. Bits 28:8 always read as zero.
- R11: A register write loads each field from the same bit positions of the written word. When a write and the overflow-enable strobe occur in the same cycle, the write takes priority.
- R12: Op codes 9 through 15 are unused and always give an overflow output of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code (0 add, 1 add-extended, 2 signed divide, 3 unsigned divide, 4 multiply-low, 5 negate, 6 subtract-from, 7 subtract-from-carrying, 8 subtract-from-extended) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| result | input | 32 | Result computed by the datapath |
| ov_en | input | 1 | Overflow-enable strobe: records the overflow decision in the register |
| wr_en | input | 1 | Packed register write strobe |
| wr_data | input | 32 | Packed word to write |
| ovf_out | output | 1 | Combinational overflow decision for the current inputs |
| rd_data | output | 32 | Packed register word |

## Verification
The bench builds the unit with its default width of 32 bits. At that width, the corner values of the most-negative-dividend rule, the negate rule and the multiply rule can be applied exactly. The 64-bit product boundary is reached from both sides: one product is exactly -2^31, which fits, and one is +2^31, which does not fit. A table of operand vectors drives every operation class, including the unused codes, with the strobe held high, so the sticky summary bit is followed across the whole sequence. Directed cases then cover hold without the strobe, write priority, the field layout of the packed word, and reset.

// File: rtl/ovf_flag_unit.sv
module ovf_flag_unit #(
  parameter int W    = 32,
  parameter int BC_W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [W-1:0] result,
  input  logic         ov_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         ovf_out,
  output logic [W-1:0] rd_data
);
  localparam int SO_BIT = W - 1;
  localparam int OV_BIT = W - 2;
  localparam int CA_BIT = W - 3;
  localparam logic [W-1:0] MOST_NEG   = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] FIELD_MASK =
    {3'b111, {(W-3-BC_W){1'b0}}, {BC_W{1'b1}}};

  localparam logic [3:0] OP_ADD   = 4'd0;
  localparam logic [3:0] OP_ADDX  = 4'd1;
  localparam logic [3:0] OP_SDIV  = 4'd2;
  localparam logic [3:0] OP_UDIV  = 4'd3;
  localparam logic [3:0] OP_MULL  = 4'd4;
  localparam logic [3:0] OP_NEG   = 4'd5;
  localparam logic [3:0] OP_SUBF  = 4'd6;
  localparam logic [3:0] OP_SUBFC = 4'd7;
  localparam logic [3:0] OP_SUBFX = 4'd8;

  logic [W-1:0] flags_q;

  // Signed-sum overflow: operands agree in sign, result sign departs from it.
  logic add_ov, sub_ov;
  assign add_ov = ~(opnd_a[W-1] ^ opnd_b[W-1]) & (opnd_a[W-1] ^ result[W-1]);
  assign sub_ov = ~(~opnd_a[W-1] ^ opnd_b[W-1]) & (~opnd_a[W-1] ^ result[W-1]);

  logic b_zero, sdiv_ov, udiv_ov, neg_ov;
  assign b_zero  = (opnd_b == '0);
  assign sdiv_ov = b_zero | ((opnd_a == MOST_NEG) & (opnd_b == '1));
  assign udiv_ov = b_zero;
  assign neg_ov  = (opnd_a == MOST_NEG);

  logic signed [2*W-1:0] a_ext, b_ext, prod;
  logic mul_ov;
  assign a_ext  = {{W{opnd_a[W-1]}}, opnd_a};
  assign b_ext  = {{W{opnd_b[W-1]}}, opnd_b};
  assign prod   = a_ext * b_ext;
  assign mul_ov = (prod[2*W-1:W] != {W{prod[W-1]}});

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDX:             ovf_out = add_ov;
      OP_SDIV:                     ovf_out = sdiv_ov;
      OP_UDIV:                     ovf_out = udiv_ov;
      OP_MULL:                     ovf_out = mul_ov;
      OP_NEG:                      ovf_out = neg_ov;
      OP_SUBF, OP_SUBFC, OP_SUBFX: ovf_out = sub_ov;
      default:                     ovf_out = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (wr_en) begin
      flags_q <= wr_data & FIELD_MASK;
    end else if (ov_en) begin
      flags_q[OV_BIT] <= ovf_out;
      flags_q[SO_BIT] <= flags_q[SO_BIT] | ovf_out;
    end
  end

  assign rd_data = flags_q;

  logic unused_ca;
  assign unused_ca = flags_q[CA_BIT];
endmodule

module ovf_flag_unit_chk #(
  parameter int W    = 32,
  parameter int BC_W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op,
  input logic [W-1:0] opnd_b,
  input logic         ov_en,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         ovf_out,
  input logic [W-1:0] rd_data
);
  localparam logic [W-1:0] FIELD_MASK =
    {3'b111, {(W-3-BC_W){1'b0}}, {BC_W{1'b1}}};

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> rd_data == '0);

  p_udiv_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd3) |-> (ovf_out == (opnd_b == '0)));

  p_sticky_so_r8: assert property (@(posedge clk) disable iff (rst)
    (ov_en && !wr_en) |=>
      (rd_data[W-1] == ($past(rd_data[W-1]) | $past(ovf_out))) &&
      (rd_data[W-2] == $past(ovf_out)) &&
      (rd_data[W-3:0] == $past(rd_data[W-3:0])));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ov_en && !wr_en) |=> $stable(rd_data));

  p_zero_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~FIELD_MASK) == '0);

  p_write_load_r11: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == ($past(wr_data) & FIELD_MASK));

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (rst)
    (op > 4'd8) |-> !ovf_out);
endmodule

bind ovf_flag_unit ovf_flag_unit_chk #(.W(W), .BC_W(BC_W)) u_chk (
  .clk(clk), .rst(rst), .op(op), .opnd_b(opnd_b), .ov_en(ov_en),
  .wr_en(wr_en), .wr_data(wr_data), .ovf_out(ovf_out), .rd_data(rd_data)
);

// File: tb/ovf_flag_unit_tb.sv
module ovf_flag_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 22;

  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  op = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, result = '0, wr_data = '0;
  logic        ov_en = 0, wr_en = 0;
  logic        ovf_out;
  logic [31:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit so_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovf_flag_unit u_dut (
    .clk(clk), .rst(rst), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .ov_en(ov_en), .wr_en(wr_en), .wr_data(wr_data),
    .ovf_out(ovf_out), .rd_data(rd_data)
  );

  // {op, a, b, result, expected overflow}
  localparam logic [100:0] VECS [0:NV-1] = '{
    {4'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1}, // R2
    {4'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0}, // R2
    {4'd1, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1}, // R2
    {4'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0}, // R2
    {4'd6, 32'h00000001, 32'h80000000, 32'h7FFFFFFF, 1'b1}, // R3
    {4'd7, 32'h00000005, 32'h0000000A, 32'h00000005, 1'b0}, // R3
    {4'd8, 32'h80000000, 32'h7FFFFFFF, 32'hFFFFFFFF, 1'b1}, // R3
    {4'd2, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 1'b1}, // R4
    {4'd2, 32'h0000000A, 32'h00000000, 32'h00000000, 1'b1}, // R4
    {4'd2, 32'h80000000, 32'h00000001, 32'h80000000, 1'b0}, // R4
    {4'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000001, 1'b0}, // R4
    {4'd3, 32'h00000007, 32'h00000000, 32'h00000000, 1'b1}, // R5
    {4'd3, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 1'b0}, // R5
    {4'd4, 32'h00010000, 32'h00010000, 32'h00000000, 1'b1}, // R6
    {4'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000001, 1'b0}, // R6
    {4'd4, 32'h00008000, 32'hFFFF0000, 32'h80000000, 1'b0}, // R6
    {4'd4, 32'h00008000, 32'h00010000, 32'h80000000, 1'b1}, // R6
    {4'd5, 32'h80000000, 32'h00000000, 32'h80000000, 1'b1}, // R7
    {4'd5, 32'hFFFFFFFF, 32'h00000000, 32'h00000001, 1'b0}, // R7
    {4'd9, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0}, // R12
    {4'd15, 32'h80000000, 32'h00000000, 32'h00000000, 1'b0}, // R12
    {4'd3, 32'h00000001, 32'h00000001, 32'h00000001, 1'b0}  // R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1 reset", rd_data, 32'h0);
    rst = 0;
    so_m = 0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op, opnd_a, opnd_b, result} = VECS[i][100:1];
      ov_en = 1;
      #1;
      check($sformatf("R2-group vector %0d ovf_out (R2 R3 R4 R5 R6 R7 R12)", i),
            {31'b0, ovf_out}, {31'b0, VECS[i][0]});
      tick();
      so_m = so_m | VECS[i][0];
      check($sformatf("R8 ov field vector %0d", i), {31'b0, rd_data[30]}, {31'b0, VECS[i][0]});
      check($sformatf("R8 so field vector %0d", i), {31'b0, rd_data[31]}, {31'b0, so_m});
    end

    // R11/R10: write all ones, then a pattern
    @(negedge clk);
    ov_en = 0; wr_en = 1; wr_data = 32'hFFFFFFFF;
    tick();
    check("R10 R11 write all ones", rd_data, 32'hE00000FF);
    @(negedge clk);
    wr_data = 32'h5A5A5A5A;
    tick();
    check("R10 R11 write pattern", rd_data, 32'h4000005A);

    // R9: overflowing op without strobe leaves all fields alone
    @(negedge clk);
    wr_en = 0; op = 4'd5; opnd_a = 32'h80000000;
    tick();
    tick();
    check("R9 hold without strobe", rd_data, 32'h4000005A);

    // R8: strobe with no overflow clears ov, so stays set, carry/count kept
    @(negedge clk);
    wr_en = 1; wr_data = 32'hA0000033;
    tick();
    @(negedge clk);
    wr_en = 0; ov_en = 1; op = 4'd0; opnd_a = 32'd1; opnd_b = 32'd1; result = 32'd2;
    tick();
    check("R8 sticky so, ov cleared, fields kept", rd_data, 32'hA0000033);
    @(negedge clk);
    opnd_a = 32'h7FFFFFFF; result = 32'h80000000;
    tick();
    check("R8 ov set again", rd_data, 32'hE0000033);

    // R11: write beats strobe
    @(negedge clk);
    wr_en = 1; wr_data = 32'h20000001; ov_en = 1;
    tick();
    check("R11 write priority over strobe", rd_data, 32'h20000001);

    // R1: reset from a loaded state
    @(negedge clk);
    wr_en = 0; ov_en = 0; wr_data = 32'hFFFFFFFF; rst = 1;
    tick();
    check("R1 reset clears loaded fields", rd_data, 32'h0);
    @(negedge clk);
    rst = 0;
    tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule